// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block sits in the command path of a synchronous DRAM controller or device model. It holds a small mode register and, for every read or write burst, produces the column address to use on each clock. Software or an init sequencer writes the register by pulsing `modeLoad` with a 14-bit word. The two top bits of the word select the target register, and only the all-zero selection reaches this one. The block decodes four settings from the word: the burst length code, the ordering (sequential or interleaved), the read latency and the write mode. A load that carries a reserved code is refused and raises an error flag.

A burst begins when `start` is pulsed with an 8-bit starting column and a read/write flag. From the next clock on, the block presents one column per cycle on `colAddr` with `colValid` high. For fixed lengths of 2, 4 and 8 the addresses stay inside the aligned block that holds the starting column, and they wrap at its edge. In a full-page burst the column counts upward through the whole row until the burst is terminated. `lastBeat` marks the final beat of a fixed-length burst. `terminate` cuts a burst short, and it allows a new start in the same cycle.

Top module: `burst_seq`

## Requirements
- R1: After reset the configuration is: length code 000 (one beat), sequential order, latency 2, burst writes enabled, `modeErr` low and `colValid` low.
- R2: A load with word bits 13:12 = 00 and no reserved code updates the configuration on the next clock. Bits 2:0 give the length code (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 gives the order (0 sequential, 1 interleaved). Bits 6:4 give the latency (010=2, 011=3), shown as `cfgLatency`. Bit 9 gives single-location writes when set.
- R3: A load with bits 13:12 = 00 is refused when any of these hold: the length code is 100, 101 or 110; bit 3 is set with length code 001 or 111; the latency code is neither 010 nor 011. A refused load sets `modeErr` and keeps the previous configuration. An accepted load clears `modeErr`.
- R4: A load whose bits 13:12 are not 00 changes neither the configuration nor `modeErr`.
- R5: A start sampled at a clock edge while idle makes beat 0 appear after that edge. After that, one column appears per clock for the programmed number of beats, and then `colValid` falls.
- R6: In sequential order, beat i of a burst of length N (2, 4 or 8) is the start column with its low log2(N) bits replaced by (start + i) mod N. Start 5 in a block of 8 gives 5,6,7,0,1,2,3,4.
- R7: In interleaved order, beat i of a burst of length 4 or 8 replaces the low bits with (start XOR i). Start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R8: With length code 000, exactly one beat is issued at the start column, whatever the order bit holds.
- R9: A full-page burst outputs start, start+1, … modulo 256, and it wraps from 255 to 0 for as long as it is not terminated.
- R10: `lastBeat` is high exactly on the final beat of a fixed-length burst and never during a full-page burst.
- R11: When bit 9 is set, a write burst is a single beat at the start column. Read bursts keep the programmed length.
- R12: A start while a burst is running is ignored unless `terminate` is high in the same cycle. In that case the new burst begins at once, with its beat 0 after that edge.
- R13: When `terminate` is sampled high at an edge during a burst, the beat shown before that edge is the last one, and `colValid` is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Load strobe for the mode word |
| modeWord | input | 14 | Mode word: select bits 13:12 and the setting fields |
| start | input | 1 | Burst start strobe |
| startCol | input | 8 | Starting column of the burst |
| isWrite | input | 1 | 1 for a write burst, 0 for a read |
| terminate | input | 1 | Ends the running burst |
| cfgLen | output | 3 | Current burst length code |
| cfgInterleave | output | 1 | Current order, 1 = interleaved |
| cfgLatency | output | 2 | Current read latency in clocks |
| cfgSingleWrite | output | 1 | Single-location write mode |
| modeErr | output | 1 | Last base-register load was refused |
| colValid | output | 1 | A burst beat is on `colAddr` |
| colAddr | output | 8 | Column address of the current beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |

## Verification
The embedded properties check on every cycle that refused and off-target loads leave the configuration alone. They also check that each step of a wrapping burst stays in its aligned block, that a full-page step adds one, that a one-beat burst shows its start column, and that `lastBeat` is followed by an idle bus. The exact beat order in sequential and interleaved modes, the beat counts for each length, the single-write override and the way start and terminate interact can only be shown by the bench. It compares every beat of directed and random bursts against a reference order it computes itself.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // burst length codes as held in the mode register
  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } burstLen_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      capture;
    logic      advance;
    burstLen_e lenSel;
    logic      interleave;
  } seqStrobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int MODE_W = 14,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              start,
  input  logic              isWrite,
  input  logic              terminate,
  output logic [2:0]        cfgLen,
  output logic              cfgInterleave,
  output logic [1:0]        cfgLatency,
  output logic              cfgSingleWrite,
  output logic              modeErr,
  output logic              colValid,
  output logic              lastBeat,
  output seqStrobe_t        strb
);

  localparam int TYPE_BIT = 3;
  localparam int LAT_LSB  = 4;
  localparam int WB_BIT   = 9;

  logic [2:0] wLen, wLat;
  logic       wIlv, wSw, baseSel, lenOk, typeOk, latOk, loadOk;
  logic       unusedBits;

  burstLen_e  lenReg, effLen;
  logic       ilvReg, swReg, errReg;
  logic [1:0] latReg;

  logic             active, fullPage, startOk, singleBeat, finalBeat;
  logic [CNT_W-1:0] beatCnt, beatTotal, totalNext;

  // mode word decode
  always_comb begin
    wLen    = modeWord[2:0];
    wIlv    = modeWord[TYPE_BIT];
    wLat    = modeWord[LAT_LSB +: 3];
    wSw     = modeWord[WB_BIT];
    baseSel = (modeWord[MODE_W-1 -: 2] == 2'b00);
    lenOk   = (wLen inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    typeOk  = !wIlv || (wLen inside {3'b000, 3'b010, 3'b011});
    latOk   = (wLat == 3'b010) || (wLat == 3'b011);
    loadOk  = lenOk && typeOk && latOk;
  end

  assign unusedBits = ^{modeWord[8:7], modeWord[MODE_W-3:10]};

  // burst shape for a new start
  always_comb begin
    singleBeat = (isWrite && swReg) || (lenReg == LEN_ONE);
    effLen     = singleBeat ? LEN_ONE : lenReg;
    case (effLen)
      LEN_TWO:   totalNext = CNT_W'(2);
      LEN_FOUR:  totalNext = CNT_W'(4);
      LEN_EIGHT: totalNext = CNT_W'(8);
      default:   totalNext = CNT_W'(1);
    endcase
  end

  assign startOk   = start && (!active || terminate);
  assign finalBeat = active && !fullPage && (beatCnt == beatTotal - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= LEN_ONE;
      ilvReg    <= 1'b0;
      latReg    <= 2'd2;
      swReg     <= 1'b0;
      errReg    <= 1'b0;
      active    <= 1'b0;
      fullPage  <= 1'b0;
      beatCnt   <= '0;
      beatTotal <= CNT_W'(1);
    end else begin
      if (modeLoad && baseSel) begin
        if (loadOk) begin
          lenReg <= burstLen_e'(wLen);
          ilvReg <= wIlv;
          latReg <= wLat[1:0];
          swReg  <= wSw;
          errReg <= 1'b0;
        end else begin
          errReg <= 1'b1;
        end
      end
      if (startOk) begin
        active    <= 1'b1;
        beatCnt   <= '0;
        beatTotal <= totalNext;
        fullPage  <= (effLen == LEN_PAGE);
      end else if (active) begin
        if (terminate || finalBeat) active <= 1'b0;
        else if (!fullPage) beatCnt <= beatCnt + CNT_W'(1);
      end
    end
  end

  assign cfgLen         = lenReg;
  assign cfgInterleave  = ilvReg;
  assign cfgLatency     = latReg;
  assign cfgSingleWrite = swReg;
  assign modeErr        = errReg;
  assign colValid       = active;
  assign lastBeat       = finalBeat;

  always_comb begin
    strb.capture    = startOk;
    strb.advance    = active && !terminate && !finalBeat && !startOk;
    strb.lenSel     = effLen;
    strb.interleave = ilvReg;
  end

  // R3
  reserved_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLoad && baseSel && !loadOk) |=> (modeErr && $stable(cfgLen) &&
      $stable(cfgInterleave) && $stable(cfgLatency) && $stable(cfgSingleWrite)));

  // R4
  bank_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLoad && !baseSel) |=> ($stable(modeErr) && $stable(cfgLen) &&
      $stable(cfgInterleave) && $stable(cfgLatency) && $stable(cfgSingleWrite)));

  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  // R10
  last_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !start) |=> !colValid);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !lastBeat && !terminate) |=> colValid);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);

  logic [COL_W-1:0] baseCol, beatIdx, wrapMask, offset;
  burstLen_e        lenSel;
  logic             ilv;

  always_comb begin
    case (lenSel)
      LEN_TWO:   wrapMask = COL_W'(1);
      LEN_FOUR:  wrapMask = COL_W'(3);
      LEN_EIGHT: wrapMask = COL_W'(7);
      LEN_PAGE:  wrapMask = '1;
      default:   wrapMask = '0;
    endcase
    offset  = ilv ? (baseCol ^ beatIdx) : (baseCol + beatIdx);
    colAddr = (baseCol & ~wrapMask) | (offset & wrapMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beatIdx <= '0;
      lenSel  <= LEN_ONE;
      ilv     <= 1'b0;
    end else if (strb.capture) begin
      baseCol <= startCol;
      beatIdx <= '0;
      lenSel  <= strb.lenSel;
      ilv     <= strb.interleave;
    end else if (strb.advance) begin
      beatIdx <= beatIdx + COL_W'(1);
    end
  end

  // R6
  block_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> ((colAddr & ~wrapMask) == $past(colAddr & ~wrapMask)));

  // R9
  page_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && lenSel == LEN_PAGE && !ilv) |=>
      (colAddr == COL_W'($past(colAddr) + COL_W'(1))));

  // R8
  single_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.lenSel == LEN_ONE) |=> (colAddr == $past(startCol)));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 14,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              start,
  input  logic [COL_W-1:0]  startCol,
  input  logic              isWrite,
  input  logic              terminate,
  output logic [2:0]        cfgLen,
  output logic              cfgInterleave,
  output logic [1:0]        cfgLatency,
  output logic              cfgSingleWrite,
  output logic              modeErr,
  output logic              colValid,
  output logic [COL_W-1:0]  colAddr,
  output logic              lastBeat
);

  seqStrobe_t strb;

  burst_seq_ctrl #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .start(start), .isWrite(isWrite), .terminate(terminate),
    .cfgLen(cfgLen), .cfgInterleave(cfgInterleave), .cfgLatency(cfgLatency),
    .cfgSingleWrite(cfgSingleWrite), .modeErr(modeErr),
    .colValid(colValid), .lastBeat(lastBeat), .strb(strb)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol), .colAddr(colAddr)
  );

endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rstN, modeLoad, start, isWrite, terminate;
  logic [13:0] modeWord;
  logic [7:0]  startCol, colAddr;
  logic [2:0]  cfgLen;
  logic [1:0]  cfgLatency;
  logic cfgInterleave, cfgSingleWrite, modeErr, colValid, lastBeat;

  burst_seq u_dut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .start(start), .startCol(startCol), .isWrite(isWrite), .terminate(terminate),
    .cfgLen(cfgLen), .cfgInterleave(cfgInterleave), .cfgLatency(cfgLatency),
    .cfgSingleWrite(cfgSingleWrite), .modeErr(modeErr),
    .colValid(colValid), .colAddr(colAddr), .lastBeat(lastBeat)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  int eLen = 0, eLat = 2;
  bit eIlv = 0, eSw = 0, eErr = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refCol(int s, int i, int len, bit ilv);
    int bs, base, off;
    case (len)
      1: bs = 2;
      2: bs = 4;
      3: bs = 8;
      7: bs = 256;
      default: bs = 1;
    endcase
    base = s - (s % bs);
    off  = s % bs;
    if (ilv) return base + (off ^ (i % bs));
    return base + ((off + i) % bs);
  endfunction

  task automatic checkCfg(string req);
    chk(req, cfgLen, eLen);
    chk(req, cfgInterleave, eIlv);
    chk(req, cfgLatency, eLat);
    chk(req, cfgSingleWrite, eSw);
    chk(req, modeErr, eErr);
  endtask

  task automatic loadMode(int w, string req);
    int len, lat;
    bit ilv, ok;
    len = w & 7; ilv = w[3]; lat = (w >> 4) & 7;
    if (((w >> 12) & 3) == 0) begin
      ok = (len <= 3 || len == 7) && (lat == 2 || lat == 3) &&
           !(ilv && (len == 1 || len == 7));
      if (ok) begin
        eLen = len; eIlv = ilv; eLat = lat; eSw = w[9]; eErr = 0;
      end else eErr = 1;
    end
    @(negedge clk);
    modeLoad = 1; modeWord = 14'(w);
    @(negedge clk);
    modeLoad = 0;
    checkCfg(req);
  endtask

  task automatic runBurst(int s, bit wr, int termAt, string req);
    bit single, full, stop;
    int nb, effLen;
    single = (wr && eSw) || eLen == 0;
    full   = (eLen == 7) && !single;
    effLen = single ? 0 : eLen;
    nb = (effLen == 1) ? 2 : (effLen == 2) ? 4 : (effLen == 3) ? 8 : 1;
    if (full && termAt < 0) termAt = 20;
    @(negedge clk);
    start = 1; startCol = 8'(s); isWrite = wr;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      start = 0;
      chk(req, colValid, 1);
      chk(req, colAddr, refCol(s, i, effLen, eIlv));
      chk("R10", lastBeat, (!full && i == nb - 1) ? 1 : 0);
      stop = (i == termAt) || (!full && i == nb - 1);
      if (i == termAt) terminate = 1;
      if (stop) break;
    end
    @(negedge clk);
    terminate = 0;
    chk(req, colValid, 0);
  endtask

  task automatic finish();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      finish();
    end
  end

  initial begin
    int w, len, lat;
    rstN = 0; modeLoad = 0; modeWord = 0; start = 0; startCol = 0;
    isWrite = 0; terminate = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkCfg("R1");
    chk("R1", colValid, 0);

    // R2 / R6: length 4 sequential, latency 3
    loadMode(14'h032, "R2");
    runBurst(6, 0, -1, "R6");
    chk("R6", refCol(6, 2, 2, 0), 4);
    // R7: length 8 interleaved, start 5 -> 5,4,7,6,1,0,3,2
    loadMode(14'h03B, "R2");
    runBurst(8'h2D, 0, -1, "R7");
    chk("R7", refCol(5, 3, 3, 1), 6);
    // R3 reserved codes
    loadMode(14'h024, "R3");
    loadMode(14'h029, "R3");
    loadMode(14'h012, "R3");
    loadMode(14'h02F, "R3");
    loadMode(14'h072, "R3");
    // R4 off-target select, error stays set
    loadMode(14'h1022, "R4");
    loadMode(14'h2000, "R4");
    // R8 length one with interleave bit set
    loadMode(14'h028, "R8");
    runBurst(8'h77, 0, -1, "R8");
    // R9 full page wrap past 255
    loadMode(14'h027, "R9");
    runBurst(250, 0, 9, "R9");
    runBurst(3, 1, 0, "R13");
    // R11 single write mode
    loadMode(14'h222, "R11");
    runBurst(8'h1D, 1, -1, "R11");
    runBurst(8'h1D, 0, -1, "R11");
    // R13 early terminate of length 8
    loadMode(14'h023, "R2");
    runBurst(8'h5A, 0, 2, "R13");

    // R12: busy start ignored, start with terminate restarts
    @(negedge clk);
    start = 1; startCol = 8'h10; isWrite = 0;
    @(negedge clk);
    chk("R12", colAddr, 8'h10);
    start = 1; startCol = 8'h40;
    @(negedge clk);
    chk("R12", colAddr, 8'h11);
    start = 0;
    @(negedge clk);
    chk("R12", colAddr, 8'h12);
    start = 1; startCol = 8'h43; terminate = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start = 0; terminate = 0;
      chk("R12", colValid, 1);
      chk("R12", colAddr, refCol(8'h43, i, 3, 0));
    end
    @(negedge clk);
    chk("R12", colValid, 0);

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      w = $urandom & 14'h3FFF;
      if ($urandom % 8 != 0) w = w & 14'h0FFF;
      lat = ($urandom % 5 == 0) ? ($urandom % 8) : (2 + $urandom % 2);
      case ($urandom % 7)
        0: len = 0; 1: len = 1; 2: len = 2; 3: len = 3; 4: len = 7;
        default: len = $urandom % 8;
      endcase
      w = (w & ~14'h077) | (lat << 4) | len;
      loadMode(w, "R2");
      runBurst($urandom % 256, 1'($urandom), ($urandom % 4 == 0) ?
               int'($urandom % 300) : -1, "R5");
    end
    finish();
  end
endmodule